// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block orders the release of resets when main power returns. An always-on crystal clock drives a free-running divider. The divider produces a slow reset clock. Once the power-good input goes high, the block waits between one and two slow-clock periods and then releases the battery-domain reset. That release crosses into the peripheral clock domain. A short counted delay follows, and then the external reset pin stops being driven low. The pin is modelled as an output enable plus a constant-low data bit, so the pad floats instead of driving high. This change happens on an auxiliary-clock edge.

A second counted delay in the peripheral domain then deasserts the internal chip reset. The crystal domain picks that up and removes the battery backup lockout. A low on the power-good input at any moment clears the whole chain asynchronously. The next rising edge of power-good starts the full sequence again from the first delay. Every crossing between domains uses a synchroniser chain.

Top module: `pwrseq_top`

## Requirements
- R1: `rst_clk_o` is a divided crystal clock with a period of exactly 2**DIV_LOG2 crystal cycles (4096 by default). It is high for exactly half of each period. The divider is cleared only by `aon_rst_n_i`, never by `pwr_good_i`.
- R2: While `aon_rst_n_i` or `pwr_good_i` is low, the outputs are held at their reset levels: `bat_rst_n_o`=0, `ext_rst_oe_o`=1 (pin driven low), `chip_rst_n_o`=0 and `lockout_o`=1.
- R3: `bat_rst_n_o` rises in the same crystal cycle as a rising edge of `rst_clk_o`. That edge is the second one counted after the synchronised power-good is seen. The total time from the rise of `pwr_good_i` is therefore between one and two slow-clock periods, plus a few crystal cycles of synchronisation. When power-good rises just after a slow-clock rise, the time is over 1.5 periods; when it rises just before one, the time is under 1.5 periods.
- R4: With the default two-stage synchronisers, `ext_rst_oe_o` falls on a rising edge of `clk_aux_i`. The fall comes between (PER_DLY+1) peripheral periods plus 2 auxiliary periods and (PER_DLY+2) peripheral periods plus 3 auxiliary periods after `bat_rst_n_o` rises. It then stays low until power is lost.
- R5: `chip_rst_n_o` rises between PER_DLY+1 and PER_DLY+2 peripheral periods after `ext_rst_oe_o` falls.
- R6: `lockout_o` falls on the third crystal rising edge after `chip_rst_n_o` rises, which is more than 2 and at most 3 crystal periods later.
- R7: The release order never breaks. The pin is never released while the battery reset is still asserted. The chip reset never deasserts while the pin is still driven. The lockout is never cleared while the chip reset is asserted.
- R8: A low on `pwr_good_i` returns all outputs to their R2 levels at once, whether it comes during the first delay or later. The next rise of `pwr_good_i` runs the whole sequence again, including a first delay of at least one full slow-clock period.
- R9: `ext_rst_o`, the data value of the reset pin, is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal_i | input | 1 | Always-on crystal clock |
| aon_rst_n_i | input | 1 | Always-on domain reset, active low |
| pwr_good_i | input | 1 | Main power good; low means power-down |
| clk_per_i | input | 1 | Peripheral clock used for the counted delays |
| clk_aux_i | input | 1 | Auxiliary CPU clock that times the pin release |
| rst_clk_o | output | 1 | Slow reset clock (crystal / 2**DIV_LOG2) |
| bat_rst_n_o | output | 1 | Battery-domain reset, active low |
| ext_rst_oe_o | output | 1 | Reset pin output enable; 1 drives the pin |
| ext_rst_o | output | 1 | Reset pin data value, constant 0 |
| chip_rst_n_o | output | 1 | Internal chip reset, active low |
| lockout_o | output | 1 | Battery backup lockout, active high |

## Verification
Almost every internal state fault shows up as a time interval outside its window at the ports. A wrong divider count changes the spacing of the `rst_clk_o` edges within one slow period. A miscounted tick moves the battery release off a slow-clock edge, or outside the one-to-two-period window, within two periods. A wrong delay count or a missing synchroniser stage moves the pin release or the chip reset by whole peripheral cycles, and this can be seen within about ten cycles of the previous step. A sequencer that does not restart on a power-good dip shows a short first delay on the next power-up.

// File: rtl/pwrseq_pkg.sv
`timescale 1ns/1ps
package pwrseq_pkg;

    // Crystal-domain sequencer phases
    typedef enum logic [1:0] {
        XS_OFF  = 2'd0,   // waiting for synchronised power good
        XS_PUD1 = 2'd1,   // counting slow-clock rises
        XS_WAIT = 2'd2,   // battery reset released, waiting for chip reset
        XS_RUN  = 2'd3    // lockout removed
    } xstate_e;

    typedef struct packed {
        xstate_e st;
        logic    tick_seen;
        logic    bat_rel;
        logic    lockout;
    } xtal_regs_t;

    localparam xtal_regs_t XTAL_RESET = '{st: XS_OFF, tick_seen: 1'b0,
                                          bat_rel: 1'b0, lockout: 1'b1};

    typedef struct packed {
        logic pin_oe;
    } aux_regs_t;

    localparam aux_regs_t AUX_RESET = '{pin_oe: 1'b1};

endpackage

// File: rtl/pwrseq_sync.sv
`timescale 1ns/1ps
module pwrseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) sh_q <= '0;
        else          sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pwrseq_div.sv
`timescale 1ns/1ps
module pwrseq_div #(
    parameter int DIV_LOG2 = 12
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic slow_clk_o,
    output logic rise_next_o
);
    // count value one cycle before the top bit rises
    localparam logic [DIV_LOG2-1:0] PRE_RISE = {1'b0, {(DIV_LOG2-1){1'b1}}};

    logic [DIV_LOG2-1:0] cnt_d;
    logic [DIV_LOG2-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) cnt_q <= '0;
        else          cnt_q <= cnt_d;
    end

    assign slow_clk_o  = cnt_q[DIV_LOG2-1];
    assign rise_next_o = (cnt_q == PRE_RISE);
endmodule

// File: rtl/pwrseq_delay.sv
`timescale 1ns/1ps
module pwrseq_delay #(
    parameter int DLY = 6
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic start_i,
    output logic done_o
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] DONE_AT = CW'(DLY);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } dly_regs_t;

    dly_regs_t r_d;
    dly_regs_t r_q;

    always_comb begin
        r_d = r_q;
        if (!start_i)             r_d.cnt = '0;
        else if (r_q.cnt != DONE_AT) r_d.cnt = r_q.cnt + 1'b1;
        r_d.done = (r_d.cnt == DONE_AT);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) r_q <= '0;
        else          r_q <= r_d;
    end

    assign done_o = r_q.done;
endmodule

// File: rtl/pwrseq_top.sv
`timescale 1ns/1ps
module pwrseq_top #(
    parameter int DIV_LOG2    = 12,
    parameter int SYNC_STAGES = 2,
    parameter int PER_DLY     = 6
) (
    input  logic clk_xtal_i,
    input  logic aon_rst_n_i,
    input  logic pwr_good_i,
    input  logic clk_per_i,
    input  logic clk_aux_i,
    output logic rst_clk_o,
    output logic bat_rst_n_o,
    output logic ext_rst_oe_o,
    output logic ext_rst_o,
    output logic chip_rst_n_o,
    output logic lockout_o
);
    import pwrseq_pkg::*;

    logic seq_rst_n;
    logic tick;
    logic pg_x;
    logic chip_x;
    logic bat_p;
    logic ext_go_p;
    logic ext_go_a;
    logic rel_p;
    logic chip_p;

    xtal_regs_t xt_d, xt_q;
    aux_regs_t  ax_d, ax_q;

    // power loss clears every sequencing flop at once
    assign seq_rst_n = pwr_good_i & aon_rst_n_i;

    // ---------------- crystal domain ----------------
    pwrseq_div #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk_i       (clk_xtal_i),
        .rst_n_i     (aon_rst_n_i),
        .slow_clk_o  (rst_clk_o),
        .rise_next_o (tick)
    );

    pwrseq_sync #(.STAGES(SYNC_STAGES)) u_sync_pg (
        .clk_i (clk_xtal_i), .rst_n_i (seq_rst_n), .d_i (1'b1), .q_o (pg_x)
    );

    pwrseq_sync #(.STAGES(SYNC_STAGES)) u_sync_chip (
        .clk_i (clk_xtal_i), .rst_n_i (seq_rst_n), .d_i (chip_p), .q_o (chip_x)
    );

    always_comb begin
        xt_d = xt_q;
        unique case (xt_q.st)
            XS_OFF: begin
                if (pg_x) begin
                    xt_d.st        = XS_PUD1;
                    xt_d.tick_seen = tick;
                end
            end
            XS_PUD1: begin
                if (tick) begin
                    if (xt_q.tick_seen) begin
                        xt_d.st      = XS_WAIT;
                        xt_d.bat_rel = 1'b1;
                    end else begin
                        xt_d.tick_seen = 1'b1;
                    end
                end
            end
            XS_WAIT: begin
                if (chip_x) begin
                    xt_d.st      = XS_RUN;
                    xt_d.lockout = 1'b0;
                end
            end
            XS_RUN: begin
                xt_d = xt_q;
            end
        endcase
    end

    always_ff @(posedge clk_xtal_i or negedge seq_rst_n) begin
        if (!seq_rst_n) xt_q <= XTAL_RESET;
        else            xt_q <= xt_d;
    end

    // ---------------- peripheral domain: pin delay ----------------
    pwrseq_sync #(.STAGES(SYNC_STAGES)) u_sync_bat (
        .clk_i (clk_per_i), .rst_n_i (seq_rst_n), .d_i (xt_q.bat_rel), .q_o (bat_p)
    );

    pwrseq_delay #(.DLY(PER_DLY)) u_dly_pin (
        .clk_i (clk_per_i), .rst_n_i (seq_rst_n), .start_i (bat_p), .done_o (ext_go_p)
    );

    // ---------------- auxiliary domain: pin release ----------------
    pwrseq_sync #(.STAGES(SYNC_STAGES)) u_sync_go (
        .clk_i (clk_aux_i), .rst_n_i (seq_rst_n), .d_i (ext_go_p), .q_o (ext_go_a)
    );

    always_comb begin
        ax_d        = ax_q;
        ax_d.pin_oe = ax_q.pin_oe & ~ext_go_a;
    end

    always_ff @(posedge clk_aux_i or negedge seq_rst_n) begin
        if (!seq_rst_n) ax_q <= AUX_RESET;
        else            ax_q <= ax_d;
    end

    // ---------------- peripheral domain: chip reset delay ----------------
    pwrseq_sync #(.STAGES(SYNC_STAGES)) u_sync_rel (
        .clk_i (clk_per_i), .rst_n_i (seq_rst_n), .d_i (~ax_q.pin_oe), .q_o (rel_p)
    );

    pwrseq_delay #(.DLY(PER_DLY)) u_dly_chip (
        .clk_i (clk_per_i), .rst_n_i (seq_rst_n), .start_i (rel_p), .done_o (chip_p)
    );

    assign bat_rst_n_o  = xt_q.bat_rel;
    assign ext_rst_oe_o = ax_q.pin_oe;
    assign ext_rst_o    = 1'b0;
    assign chip_rst_n_o = chip_p;
    assign lockout_o    = xt_q.lockout;
endmodule

// File: rtl/pwrseq_chk.sv
`timescale 1ns/1ps
module pwrseq_chk (
    input logic clk_xtal_i,
    input logic clk_per_i,
    input logic clk_aux_i,
    input logic aon_rst_n_i,
    input logic pwr_good_i,
    input logic rst_clk_o,
    input logic bat_rst_n_o,
    input logic ext_rst_oe_o,
    input logic chip_rst_n_o,
    input logic lockout_o
);
    // slow clock stays high at least one cycle after rising
    assert_slow_clk_high_R1: assert property (@(posedge clk_xtal_i)
        disable iff (!aon_rst_n_i)
        $rose(rst_clk_o) |=> rst_clk_o);

    // battery release lands on a slow-clock rise
    assert_bat_on_tick_R3: assert property (@(posedge clk_xtal_i)
        disable iff (!(pwr_good_i && aon_rst_n_i))
        $rose(bat_rst_n_o) |-> $rose(rst_clk_o));

    // once released, the pin stays released
    assert_pin_stays_off_R4: assert property (@(posedge clk_aux_i)
        disable iff (!(pwr_good_i && aon_rst_n_i))
        $fell(ext_rst_oe_o) |=> !ext_rst_oe_o);

    // pin released only after battery reset
    assert_pin_after_bat_R7: assert property (@(posedge clk_aux_i)
        disable iff (!(pwr_good_i && aon_rst_n_i))
        !ext_rst_oe_o |-> bat_rst_n_o);

    // chip reset deasserts only after pin release
    assert_chip_after_pin_R5: assert property (@(posedge clk_per_i)
        disable iff (!(pwr_good_i && aon_rst_n_i))
        chip_rst_n_o |-> !ext_rst_oe_o);

    // lockout cleared only with chip reset deasserted
    assert_lock_after_chip_R6: assert property (@(posedge clk_xtal_i)
        disable iff (!(pwr_good_i && aon_rst_n_i))
        !lockout_o |-> chip_rst_n_o);

    // power loss holds everything in reset
    always @(posedge clk_per_i) begin
        if (!pwr_good_i) begin
            assert_off_state_R8: assert (!bat_rst_n_o && ext_rst_oe_o &&
                                         !chip_rst_n_o && lockout_o)
                else $error("outputs not in reset state during power loss");
        end
    end
endmodule

bind pwrseq_top pwrseq_chk u_chk (
    .clk_xtal_i   (clk_xtal_i),
    .clk_per_i    (clk_per_i),
    .clk_aux_i    (clk_aux_i),
    .aon_rst_n_i  (aon_rst_n_i),
    .pwr_good_i   (pwr_good_i),
    .rst_clk_o    (rst_clk_o),
    .bat_rst_n_o  (bat_rst_n_o),
    .ext_rst_oe_o (ext_rst_oe_o),
    .chip_rst_n_o (chip_rst_n_o),
    .lockout_o    (lockout_o)
);

// File: tb/pwrseq_top_test.sv
`timescale 1ns/1ps
module pwrseq_top_test;
    localparam int  DIV_LOG2 = 12;
    localparam int  PER_DLY  = 6;
    localparam real T_AUX = 8.0;
    localparam real T_PER = 11.0;
    localparam real T_XT  = 17.0;
    localparam real P     = (1 << DIV_LOG2) * T_XT;

    logic clk_aux = 1'b0, clk_per = 1'b0, clk_xt = 1'b0;
    logic aon_rst_n = 1'b1, pwr_good = 1'b1;
    logic rst_clk, bat_rst_n, ext_oe, ext_dat, chip_rst_n, lockout;

    int  checks = 0;
    int  errors = 0;
    real last_rise = 0.0;

    always #(T_AUX/2) clk_aux = ~clk_aux;
    always #(T_PER/2) clk_per = ~clk_per;
    always #(T_XT/2)  clk_xt  = ~clk_xt;

    always @(posedge rst_clk) last_rise = $realtime;

    pwrseq_top #(.DIV_LOG2(DIV_LOG2), .SYNC_STAGES(2), .PER_DLY(PER_DLY)) uut (
        .clk_xtal_i   (clk_xt),
        .aon_rst_n_i  (aon_rst_n),
        .pwr_good_i   (pwr_good),
        .clk_per_i    (clk_per),
        .clk_aux_i    (clk_aux),
        .rst_clk_o    (rst_clk),
        .bat_rst_n_o  (bat_rst_n),
        .ext_rst_oe_o (ext_oe),
        .ext_rst_o    (ext_dat),
        .chip_rst_n_o (chip_rst_n),
        .lockout_o    (lockout)
    );

    task automatic chk_val(input string req, input string what, input real act, input real exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input real act,
                           input real lo, input real hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f..%0.3f", req, what, act, lo, hi);
        end
    endtask

    task automatic check_off(input string req);
        chk_val(req, "bat_rst_n", real'(bat_rst_n), 0.0);
        chk_val(req, "ext_rst_oe", real'(ext_oe), 1.0);
        chk_val(req, "chip_rst_n", real'(chip_rst_n), 0.0);
        chk_val(req, "lockout", real'(lockout), 1.0);
        chk_val("R9", "ext_rst data", real'(ext_dat), 0.0);
    endtask

    // R2: reset levels under battery reset and under power loss
    task automatic t_reset();
        #1;
        aon_rst_n = 1'b0;
        pwr_good  = 1'b0;
        #(10*T_XT);
        check_off("R2");
        chk_val("R1", "divider cleared by battery reset", real'(rst_clk), 0.0);
        aon_rst_n = 1'b1;
        #(30*T_XT);
        check_off("R2");
    endtask

    // R1: slow clock period and duty
    task automatic t_divider();
        real r0, f0, r1;
        @(posedge rst_clk); r0 = $realtime;
        @(negedge rst_clk); f0 = $realtime;
        @(posedge rst_clk); r1 = $realtime;
        chk_val("R1", "slow clock period", r1 - r0, P);
        chk_val("R1", "slow clock high time", f0 - r0, P/2);
    endtask

    // R3..R7, R9: full power-up with a chosen phase of power good
    task automatic t_sequence(input string name, input bit late);
        real t0, t1, t2, t3, t4;
        pwr_good = 1'b0;
        #(20*T_XT);
        check_off("R8");
        @(posedge rst_clk);
        if (late) begin
            #(3*T_XT + T_XT/2);
        end else begin
            @(negedge rst_clk);
            #(((1 << (DIV_LOG2-1)) - 5)*T_XT + T_XT/2);
        end
        pwr_good = 1'b1;
        t0 = $realtime;

        @(posedge bat_rst_n); t1 = $realtime;
        #1;
        chk_val("R3", {name, " release on slow clock rise"}, last_rise, t1);
        chk_rng("R3", {name, " first delay"}, t1 - t0, P, 2*P + 5*T_XT);
        if (late) chk_rng("R3", "late phase gives near two periods", t1 - t0, 1.5*P, 2*P + 5*T_XT);
        else      chk_rng("R3", "early phase gives near one period", t1 - t0, P, 1.5*P);
        chk_val("R7", "pin still driven at battery release", real'(ext_oe), 1.0);
        chk_val("R7", "chip still reset at battery release", real'(chip_rst_n), 0.0);

        @(negedge ext_oe); t2 = $realtime;
        chk_rng("R4", {name, " pin release delay"}, t2 - t1,
                (PER_DLY+1)*T_PER + 2*T_AUX - 1.0, (PER_DLY+2)*T_PER + 3*T_AUX + 1.0);
        chk_val("R4", "pin release on aux rising edge", real'(int'(t2) % 8), 4.0);
        #1;
        chk_val("R7", "chip still reset at pin release", real'(chip_rst_n), 0.0);

        @(posedge chip_rst_n); t3 = $realtime;
        chk_rng("R5", {name, " chip reset delay"}, t3 - t2,
                (PER_DLY+1)*T_PER - 1.0, (PER_DLY+2)*T_PER + 1.0);
        #1;
        chk_val("R7", "lockout held at chip release", real'(lockout), 1.0);

        @(negedge lockout); t4 = $realtime;
        chk_rng("R6", {name, " lockout removal delay"}, t4 - t3, 2*T_XT - 1.0, 3*T_XT + 1.0);

        #(50*T_XT);
        chk_val("R7", "battery reset stays released", real'(bat_rst_n), 1.0);
        chk_val("R4", "pin stays released", real'(ext_oe), 0.0);
        chk_val("R7", "chip stays running", real'(chip_rst_n), 1.0);
        chk_val("R6", "lockout stays cleared", real'(lockout), 0.0);
        chk_val("R9", "ext_rst data after release", real'(ext_dat), 0.0);
    endtask

    // R8: power dips in the first delay and after battery release
    task automatic t_abort();
        real t0, t1;
        pwr_good = 1'b0;
        #(20*T_XT);
        check_off("R8");

        pwr_good = 1'b1;
        #(P/2);
        chk_val("R8", "no release half way through first delay", real'(bat_rst_n), 0.0);
        pwr_good = 1'b0;
        #(20*T_XT);
        check_off("R8");

        pwr_good = 1'b1;
        t0 = $realtime;
        @(posedge bat_rst_n); t1 = $realtime;
        chk_rng("R8", "restart after dip in first delay", t1 - t0, P, 2*P + 5*T_XT);
        #(3*T_PER);
        pwr_good = 1'b0;
        #1;
        check_off("R8");
        #(20*T_XT);

        pwr_good = 1'b1;
        t0 = $realtime;
        @(posedge bat_rst_n); t1 = $realtime;
        chk_rng("R8", "restart after dip in second delay", t1 - t0, P, 2*P + 5*T_XT);
        @(negedge lockout);
        #1;
        chk_val("R8", "sequence completes after restart", real'(chip_rst_n), 1.0);
    endtask

    initial begin
        #(190000*8);
        errors++;
        $display("FAIL R7 watchdog: actual timeout expected sequence completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_divider();
        t_sequence("late", 1'b1);
        t_sequence("early", 1'b0);
        t_abort();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule